// File: doc/BRIEF.md
# Peripheral Clock Source-Select, Divide and Gate Controller

This block produces six peripheral clock enables from one fast system clock. Four tick inputs stand for the primary and secondary outputs of two PLL-derived sources. A fifth tick input stands for the crystal. Each channel picks its input, either through a 2-bit select field or by a fixed wiring. It then divides that input by zero, one or two integer stages and can be switched off by a disable bit. Every output is a one-cycle enable pulse at the resulting rate. It is not a derived clock. Consumers use it as a clock enable inside the fast domain.

Software programs six 32-bit word registers over a simple read/write bus. A channel's divisor is the product of its stage divisors. An unmapped divider code stops the channel. One channel takes the output of another channel as its input, which forms a two-level tree.

Top module: `pclk_ctrl`

Channel layout. The select word is at 0x00, the divider words are at 0x04, 0x08 and 0x0C, and the disable word is at 0x14.
- ch0: select bits [1:0]; stages at 0x0C bits [2:0] and [5:3]; disable bit 0.
- ch1: select bits [3:2]; one stage at 0x04 bits [2:0]; disable bit 1.
- ch2: select bits [5:4]; stages at 0x08 bits [2:0] and [5:3]; it has no gate, so disable bit 2 is ignored.
- ch3: fixed to the crystal tick; no divider; disable bit 3.
- ch4: fixed to source tick 2; a 1-bit stage at 0x04 bit 8; disable bit 4.
- ch5: fed by the ch2 output; a 1-bit stage at 0x04 bit 9; disable bit 5.

## Requirements
- R1: The bus decodes word addresses. 0x00 is the select word, 0x04, 0x08 and 0x0C are the divider words, 0x10 is a plain storage word and 0x14 is the disable word. Reads return the stored word. Reads of any other address return 0, and writes to any other address change nothing. All six words reset to 0.
- R2: A select code of 0, 1, 2 or 3 routes `src_tick[0]`, `[1]`, `[2]` or `[3]` to the channel. These are A primary, B primary, A secondary and B secondary.
- R3: A 3-bit divider code of 1 to 6 divides by that value. Codes 0 and 7 stop the channel, so it emits no pulses.
- R4: A channel with two stages divides by the product of the two stage divisors.
- R5: The 1-bit fields use two encodings. On ch4, code 1 divides by 2. On ch5, code 1 divides by 1. On both, code 0 stops the channel.
- R6: A disable bit of 1 stops the output of a gated channel. A disable bit of 0 lets it run. ch2 runs whatever the value of bit 2.
- R7: ch5 divides the pulse train that ch2 emits.
- R8: A new divider code takes effect only when the running period reaches its terminal count, so no period is shortened. A stopped stage picks up a new code at once.
- R9: A change of a channel's select code clears that channel's counters. Counting restarts with the next pulse of the newly selected source.
- R10: `ch_tick` is registered. A source pulse that completes a period appears on `ch_tick` one cycle later, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| src_tick | input | 4 | Source tick pulses: A primary, B primary, A secondary, B secondary |
| xtal_tick | input | 1 | Crystal tick pulse |
| ch_tick | output | 6 | Channel enable pulses |

## Verification
Read data is due in the same cycle as the address. A write becomes visible on the clock edge that accepts it. Channel logic uses the new value from the next edge on. A source pulse that closes a period shows on `ch_tick` one edge later. ch5 lags ch2 by one further edge, and a select change clears the counters on the edge after its write. The bench advances a behavioural model on every rising edge from the requirements. It compares all six outputs at the following falling edge, so each output is checked exactly in the cycle it is due. Windowed pulse counts and measured gaps between pulses confirm the division ratios and when a divisor change takes hold.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int NUM_CH   = 6;
  localparam int NUM_SRC  = 4;
  localparam int NUM_REG  = 6;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int DIV_W    = 3;
  localparam int SEL_W    = 2;
  localparam int IDX_W    = ADDR_W - 2;

  localparam int REG_SEL  = 0;
  localparam int REG_DIS  = 5;

  typedef enum logic [1:0] {
    ENC_STD  = 2'd0,
    ENC_HALF = 2'd1,
    ENC_UNIT = 2'd2
  } div_enc_e;

  typedef struct packed {
    logic       has_mux;
    logic [4:0] mux_sh;
    logic [2:0] fixed_src;
    logic       from_ch;
    logic [2:0] parent_ch;
    logic [1:0] ndiv;
    logic [2:0] div_reg;
    logic [4:0] sh0;
    logic [4:0] sh1;
    div_enc_e   enc;
    logic       has_gate;
    logic [4:0] gate_bit;
  } ch_cfg_t;

  function automatic ch_cfg_t chan_cfg(int idx);
    ch_cfg_t c;
    c = '0;
    c.enc     = ENC_STD;
    c.div_reg = 3'd1;
    case (idx)
      0: begin
        c.has_mux = 1'b1; c.mux_sh = 5'd0; c.ndiv = 2'd2; c.div_reg = 3'd3;
        c.sh0 = 5'd0; c.sh1 = 5'd3; c.has_gate = 1'b1; c.gate_bit = 5'd0;
      end
      1: begin
        c.has_mux = 1'b1; c.mux_sh = 5'd2; c.ndiv = 2'd1; c.div_reg = 3'd1;
        c.sh0 = 5'd0; c.has_gate = 1'b1; c.gate_bit = 5'd1;
      end
      2: begin
        c.has_mux = 1'b1; c.mux_sh = 5'd4; c.ndiv = 2'd2; c.div_reg = 3'd2;
        c.sh0 = 5'd0; c.sh1 = 5'd3; c.has_gate = 1'b0; c.gate_bit = 5'd2;
      end
      3: begin
        c.fixed_src = 3'd4; c.ndiv = 2'd0; c.has_gate = 1'b1; c.gate_bit = 5'd3;
      end
      4: begin
        c.fixed_src = 3'd2; c.ndiv = 2'd1; c.div_reg = 3'd1; c.sh0 = 5'd8;
        c.enc = ENC_HALF; c.has_gate = 1'b1; c.gate_bit = 5'd4;
      end
      default: begin
        c.from_ch = 1'b1; c.parent_ch = 3'd2; c.ndiv = 2'd1; c.div_reg = 3'd1;
        c.sh0 = 5'd9; c.enc = ENC_UNIT; c.has_gate = 1'b1; c.gate_bit = 5'd5;
      end
    endcase
    return c;
  endfunction

  function automatic logic [DIV_W-1:0] decode_div(div_enc_e enc, logic [DIV_W-1:0] code);
    logic [DIV_W-1:0] d;
    d = '0;
    case (enc)
      ENC_STD:  d = (code >= DIV_W'(1) && code <= DIV_W'(6)) ? code : '0;
      ENC_HALF: d = (code == DIV_W'(1)) ? DIV_W'(2) : '0;
      default:  d = (code == DIV_W'(1)) ? DIV_W'(1) : '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_en,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_REG-1:0][DATA_W-1:0] regs_o
);
  logic [NUM_REG-1:0][DATA_W-1:0] regs_q, regs_d;
  logic [IDX_W-1:0]               idx;
  logic                           mapped;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign mapped = (bus_addr[1:0] == 2'b00) && (int'(idx) < NUM_REG);

  always_comb begin
    regs_d = regs_q;
    if (bus_en && bus_we && mapped) begin
      regs_d[idx] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      bus_rdata = regs_q[idx];
    end
  end

  assign regs_o = regs_q;

  p_sel_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(0)) |=> (regs_q[REG_SEL] == $past(bus_wdata)));

  p_unmapped_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !mapped) |=> $stable(regs_q));
endmodule

// File: rtl/pclk_div_stage.sv
module pclk_div_stage #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_en,
  input  logic [CW-1:0] new_div,
  output logic          out_en
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] div_q, div_d;
  logic          term;

  always_comb begin
    term   = (div_q != '0) && (cnt_q == CW'(div_q - 1'b1));
    out_en = in_en & term & ~clr;
    cnt_d  = cnt_q;
    div_d  = div_q;
    if (clr) begin
      cnt_d = '0;
      div_d = new_div;
    end else if (div_q == '0) begin
      cnt_d = '0;
      div_d = new_div;
    end else if (in_en) begin
      if (term) begin
        cnt_d = '0;
        div_d = new_div;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> in_en);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt_q < div_q));

  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && div_q != '0 && !(in_en && term)) |=> $stable(div_q));

  p_stopped_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !out_en);
endmodule

// File: rtl/pclk_channel.sv
module pclk_channel
  import pclk_pkg::*;
#(
  parameter ch_cfg_t CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  input  logic [DIV_W-1:0] code0,
  input  logic [DIV_W-1:0] code1,
  input  logic             gate_off,
  input  logic [NUM_SRC:0] src_vec,
  input  logic             parent_tick,
  output logic             tick_q
);
  logic             clr;
  logic             src_pulse;
  logic             div_out;
  logic             gate_now;
  logic             tick_d;
  logic [DIV_W-1:0] nd0, nd1;
  logic             unused_in;

  assign unused_in = ^{sel_code, code0, code1, gate_off, src_vec, parent_tick};

  assign nd0 = decode_div(CFG.enc, code0);
  assign nd1 = decode_div(ENC_STD, code1);

  if (CFG.has_mux) begin : g_mux
    logic [SEL_W-1:0] sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
      end else begin
        sel_q <= sel_code;
      end
    end
    assign clr       = (sel_code != sel_q);
    assign src_pulse = src_vec[sel_code];

    p_mux_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick_q);
  end else begin : g_fixed
    assign clr = 1'b0;
    if (CFG.from_ch) begin : g_child
      assign src_pulse = parent_tick;
    end else begin : g_root
      assign src_pulse = src_vec[CFG.fixed_src];
    end
  end

  if (CFG.ndiv == 2'd0) begin : g_nodiv
    assign div_out = src_pulse;
  end else begin : g_div
    logic mid;
    pclk_div_stage #(.CW(DIV_W)) u_st0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .in_en   (src_pulse),
      .new_div (nd0),
      .out_en  (mid)
    );
    if (CFG.ndiv == 2'd2) begin : g_two
      pclk_div_stage #(.CW(DIV_W)) u_st1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .in_en   (mid),
        .new_div (nd1),
        .out_en  (div_out)
      );
    end else begin : g_one
      assign div_out = mid;
    end
  end

  if (CFG.has_gate) begin : g_gate
    assign gate_now = gate_off;
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_off |=> !tick_q);
  end else begin : g_nogate
    assign gate_now = 1'b0;
  end

  assign tick_d = div_out & ~gate_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  p_tick_from_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(src_pulse));
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  src_tick,
  input  logic                xtal_tick,
  output logic [NUM_CH-1:0]   ch_tick
);
  logic [NUM_REG-1:0][DATA_W-1:0] regs;
  logic [NUM_SRC:0]               src_vec;

  assign src_vec = {xtal_tick, src_tick};

  pclk_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .regs_o    (regs)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam ch_cfg_t C = chan_cfg(g);
    logic [DATA_W-1:0] dword;
    logic [DIV_W-1:0]  c0, c1;

    assign dword = regs[C.div_reg];
    if (C.enc == ENC_STD) begin : g_wide
      assign c0 = dword[C.sh0 +: DIV_W];
    end else begin : g_bit
      assign c0 = {{(DIV_W-1){1'b0}}, dword[C.sh0]};
    end
    assign c1 = dword[C.sh1 +: DIV_W];

    pclk_channel #(.CFG(C)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_code    (regs[REG_SEL][C.mux_sh +: SEL_W]),
      .code0       (c0),
      .code1       (c1),
      .gate_off    (regs[REG_DIS][C.gate_bit]),
      .src_vec     (src_vec),
      .parent_tick (ch_tick[C.parent_ch]),
      .tick_q      (ch_tick[g])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ch_tick == '0));
endmodule

// File: tb/sim_pclk_ctrl.sv
module sim_pclk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic        xtal_tick;
  logic [5:0]  ch_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pclk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .xtal_tick(xtal_tick), .ch_tick(ch_tick)
  );

  // tick stimulus
  logic [4:0]  ones_mask = 5'b0;
  logic [4:0]  rand_mask = 5'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < 4; i++)
      src_tick[i] <= ones_mask[i] | (rand_mask[i] & lfsr[i*3]);
    xtal_tick <= ones_mask[4] | (rand_mask[4] & lfsr[14]);
  end

  // behavioural model
  logic [31:0] mreg [6];
  int          mcnt [6][2];
  int          mdiv [6][2];
  int          psel [6];
  bit [5:0]    eout;
  int          cyc = 0;

  function automatic int dstd(int code);
    return (code >= 1 && code <= 6) ? code : 0;
  endfunction

  task automatic stage(int c, int s, bit in_p, int nd, bit clr_p, output bit o);
    o = 1'b0;
    if (clr_p) begin
      mcnt[c][s] = 0; mdiv[c][s] = nd;
    end else if (mdiv[c][s] == 0) begin
      mcnt[c][s] = 0; mdiv[c][s] = nd;
    end else if (in_p) begin
      if (mcnt[c][s] == mdiv[c][s] - 1) begin
        o = 1'b1; mcnt[c][s] = 0; mdiv[c][s] = nd;
      end else begin
        mcnt[c][s] = mcnt[c][s] + 1;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        mreg[i] = 0; psel[i] = 0; mcnt[i][0] = 0; mcnt[i][1] = 0;
        mdiv[i][0] = 0; mdiv[i][1] = 0;
      end
      eout = '0;
    end else begin
      bit [5:0] nxt;
      bit o, o2, cl;
      int f;
      bit [4:0] sv;
      cyc++;
      sv = {xtal_tick, src_tick};
      nxt = '0;
      // ch0
      f = int'(mreg[0][1:0]); cl = (f != psel[0]);
      stage(0, 0, sv[f], dstd(int'(mreg[3][2:0])), cl, o);
      stage(0, 1, o, dstd(int'(mreg[3][5:3])), cl, o2);
      nxt[0] = o2 && !mreg[5][0]; psel[0] = f;
      // ch1
      f = int'(mreg[0][3:2]); cl = (f != psel[1]);
      stage(1, 0, sv[f], dstd(int'(mreg[1][2:0])), cl, o);
      nxt[1] = o && !mreg[5][1]; psel[1] = f;
      // ch2 (no gate)
      f = int'(mreg[0][5:4]); cl = (f != psel[2]);
      stage(2, 0, sv[f], dstd(int'(mreg[2][2:0])), cl, o);
      stage(2, 1, o, dstd(int'(mreg[2][5:3])), cl, o2);
      nxt[2] = o2; psel[2] = f;
      // ch3
      nxt[3] = sv[4] && !mreg[5][3];
      // ch4
      stage(4, 0, sv[2], mreg[1][8] ? 2 : 0, 1'b0, o);
      nxt[4] = o && !mreg[5][4];
      // ch5 from previous ch2 output
      stage(5, 0, eout[2], mreg[1][9] ? 1 : 0, 1'b0, o);
      nxt[5] = o && !mreg[5][5];
      eout = nxt;
      if (bus_en && bus_we && bus_addr[1:0] == 2'b00 && bus_addr[4:2] < 3'd6)
        mreg[bus_addr[4:2]] = bus_wdata;
    end
  end

  // per-cycle comparison (R2 R3 R4 R5 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (ch_tick !== eout) begin
        failures++;
        $display("FAIL R10 cycle %0d ch_tick actual %b expected %b", cyc, ch_tick, eout);
      end
    end
  end

  // pulse timestamps for ch1
  int q1[$];
  always @(negedge clk) if (rst_n === 1'b1 && ch_tick[1]) q1.push_back(cyc);

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", tag, a, bus_rdata, exp);
    end
    bus_en = 1'b0;
  endtask

  task automatic count_win(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch_tick[ch]) cnt++;
    end
  endtask

  task automatic expect_near(input int act, input int exp, input int tol, input string tag);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic all_counts(input int n, output int c [6]);
    for (int k = 0; k < 6; k++) c[k] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 6; k++) if (ch_tick[k]) c[k]++;
    end
  endtask

  initial begin
    int c [6];
    int n;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_tick = '0; xtal_tick = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 6; i++) rd_check(5'(i * 4), 32'h0, "R1 reset");
    checks++;
    if (ch_tick !== 6'b0) begin
      failures++;
      $display("FAIL R1 reset ch_tick actual %b expected 000000", ch_tick);
    end
    // R1 storage, unmapped
    wr(5'h10, 32'hA5A5_0F0F);
    rd_check(5'h10, 32'hA5A5_0F0F, "R1 storage");
    wr(5'h18, 32'hFFFF_FFFF);
    rd_check(5'h18, 32'h0, "R1 unmapped");
    rd_check(5'h10, 32'hA5A5_0F0F, "R1 unmapped-write");
    rd_check(5'h00, 32'h0, "R1 unmapped-write");
    // program channels
    wr(5'h00, 32'h34);
    wr(5'h0C, 32'h1A);
    wr(5'h04, 32'h305);
    wr(5'h08, 32'h12);
    rd_check(5'h04, 32'h305, "R1 divider word");
    // R3 R4 R5 R6 R7 ratio counts with all sources ticking every cycle
    ones_mask = 5'b11111;
    repeat (40) @(negedge clk);
    all_counts(600, c);
    expect_near(c[0], 100, 1, "R4 ch0 divide 2x3");
    expect_near(c[1], 120, 1, "R3 ch1 divide 5");
    expect_near(c[2], 150, 1, "R4 ch2 divide 2x2");
    expect_near(c[3], 600, 0, "R6 ch3 ungated crystal");
    expect_near(c[4], 300, 1, "R5 ch4 half code");
    expect_near(c[5], 150, 1, "R7 ch5 follows ch2");
    // R3 unmapped codes
    wr(5'h04, 32'h307);
    repeat (20) @(negedge clk);
    count_win(1, 200, n);
    expect_near(n, 0, 0, "R3 ch1 code 7 stops");
    wr(5'h04, 32'h300);
    repeat (20) @(negedge clk);
    count_win(1, 200, n);
    expect_near(n, 0, 0, "R3 ch1 code 0 stops");
    // R5 ch5 code 0 stops
    wr(5'h04, 32'h105);
    repeat (20) @(negedge clk);
    count_win(5, 200, n);
    expect_near(n, 0, 0, "R5 ch5 code 0 stops");
    wr(5'h04, 32'h305);
    // R6 gating
    wr(5'h14, 32'h3F);
    repeat (10) @(negedge clk);
    all_counts(400, c);
    expect_near(c[0] + c[1] + c[3] + c[4] + c[5], 0, 0, "R6 gated channels silent");
    expect_near(c[2], 100, 1, "R6 ch2 ignores its bit");
    wr(5'h14, 32'h0);
    repeat (40) @(negedge clk);
    count_win(3, 100, n);
    expect_near(n, 100, 0, "R6 cleared bit runs");
    // R8 divisor change at terminal count only
    q1.delete();
    wait (q1.size() >= 1);
    wr(5'h04, 32'h302);
    wait (q1.size() >= 3);
    expect_near(q1[1] - q1[0], 5, 0, "R8 old period completes");
    expect_near(q1[2] - q1[1], 2, 0, "R8 new period");
    // R2 source select, R9 mux change
    ones_mask = 5'b11101;
    repeat (20) @(negedge clk);
    count_win(1, 100, n);
    expect_near(n, 0, 0, "R2 ch1 follows quiet source 1");
    wr(5'h00, 32'h30);
    count_win(1, 100, n);
    expect_near(n, 50, 1, "R9 ch1 restarts on source 0");
    wr(5'h00, 32'h38);
    count_win(1, 100, n);
    expect_near(n, 50, 1, "R2 ch1 on source 2");
    // random phase with register churn
    ones_mask = 5'b0;
    rand_mask = 5'b11111;
    for (int k = 0; k < 12; k++) begin
      repeat (250) @(negedge clk);
      wr(5'h00, 32'((k * 37) & 8'h3F));
      wr(5'h0C, 32'((k * 11 + 9) & 8'h3F));
      wr(5'h04, 32'(((k & 3) << 8) | (k % 8)));
      wr(5'h08, 32'((k * 19 + 10) & 8'h3F));
      wr(5'h14, 32'((k * 5) & 8'h3F));
    end
    repeat (100) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule